// File: doc/BRIEF.md
# Multi-Cycle Fetch-Execute Sequencer

This block is the control core of a small load/store processor that runs one instruction at a time. It holds a program counter, a flag bit set by compares, an instruction register and a sixteen-entry register file of 32-bit words. It fetches each instruction through a valid/ready request port and a separate response port. When the word comes back, the block executes it in the same cycle. Loads and stores add a second round trip on a data port of the same shape. The program counter moves on only when that data reply has arrived.

Arithmetic, logic and compare results come from an external execute unit. The block presents a function code and two operands to that unit and takes back a result word and a compare flag. A stop instruction halts the block. It also halts once a cycle counter, started at reset, reaches two to the power of a parameter. In both cases the `halted` output stays high until the next reset.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is low, and until the first fetch is accepted after it, `imem_req_valid` is 1 with `imem_req_addr` 0, `dmem_req_valid` is 0, `halted` is 0, and all registers and the flag are zero.
- R2: A request is held with a stable address until its ready is seen. At most one request is in flight, so instruction and data requests are never valid together. An instruction is executed in the cycle its `imem_rsp_valid` is seen.
- R3: Instruction fields are: opcode [31:27], rd [26:23], rs1 [22:19], rs2 [18:15], and a 16-bit immediate [15:0] that is sign-extended to 32 bits. Opcodes are 0 no-op, 1 stop, 2 jump, 3 register jump, 4 branch, 5 load-immediate, 6 load and 7 store. Opcodes 8+f are register ALU operations, 16+f are immediate ALU operations and 24+f are compares, with f on `alu_func`.
- R4: Register and immediate ALU operations write `alu_result` to rd. `alu_a` is rs1, and `alu_b` is rs2 or the immediate. Load-immediate writes the immediate. All three then fetch from PC+1. A no-op only advances the PC.
- R5: A write that targets register 0 stores zero.
- R6: A jump sets the PC to the immediate. A register jump sets it to the value of rs1.
- R7: A compare sets the flag to `alu_flag` and advances the PC. A branch goes to the immediate when the flag is 1 and to PC+1 otherwise.
- R8: A load reads at rs1 plus the immediate, with `dmem_req_we` 0. The returned word is written to rd, and the PC then advances by one.
- R9: A store writes the value of rd at rs1 plus the immediate, with `dmem_req_we` 1. The PC advances only after the data response.
- R10: A `dmem_rsp_valid` pulse with no load or store outstanding changes no state.
- R11: A stop instruction raises `halted` in the next cycle, and no further requests are issued.
- R12: With no stop, `halted` is 0 after 2^LOG_MAX_CYCLES-1 clock edges after reset and 1 after 2^LOG_MAX_CYCLES edges, and it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| imem_req_valid | output | 1 | Instruction fetch request |
| imem_req_ready | input | 1 | Fetch request accepted |
| imem_req_addr | output | 32 | Fetch address (PC) |
| imem_rsp_valid | input | 1 | Instruction word returned |
| imem_rsp_data | input | 32 | Instruction word |
| dmem_req_valid | output | 1 | Data access request |
| dmem_req_ready | input | 1 | Data request accepted |
| dmem_req_we | output | 1 | 1 store, 0 load |
| dmem_req_addr | output | 32 | Data address |
| dmem_req_wdata | output | 32 | Store data |
| dmem_rsp_valid | input | 1 | Data response |
| dmem_rsp_data | input | 32 | Load data |
| alu_func | output | 3 | Function code for the execute unit |
| alu_a | output | 32 | First operand |
| alu_b | output | 32 | Second operand |
| alu_result | input | 32 | Execute unit result |
| alu_flag | input | 1 | Execute unit compare outcome |
| halted | output | 1 | Stopped by instruction or cycle limit |

## Verification
A stray data response can arrive in the same cycle that an instruction word is consumed, or while a data request is still waiting for ready. In either case the block must ignore it while it executes the instruction. The responder in the bench injects such pulses every fifth cycle whenever no data access is outstanding. Both ready lines are also stalled in a fixed pattern. The effect is judged through later stores and the load result: any stray word that reached a register would show up in the captured store data.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 16;

  typedef enum logic [2:0] {ST_FETCH, ST_IWAIT, ST_DREQ, ST_DWAIT, ST_HALT} state_e;

  typedef enum logic [3:0] {
    K_NOP, K_STOP, K_JMP, K_JREG, K_BRC, K_LDI, K_LOAD, K_STORE, K_ALU, K_ALUI, K_CMP
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic [2:0]       func;
    logic [RIDX-1:0]  rd;
    logic [RIDX-1:0]  rs1;
    logic [RIDX-1:0]  rs2;
    logic [XLEN-1:0]  imm;
  } dec_t;
endpackage

// File: rtl/fes_decode.sv
module fes_decode
  import fes_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  always_comb begin
    dec.rd   = word[26:23];
    dec.rs1  = word[22:19];
    dec.rs2  = word[18:15];
    dec.func = word[29:27];
    dec.imm  = {{(XLEN-IMMW){word[IMMW-1]}}, word[IMMW-1:0]};
    unique case (word[31:30])
      2'b01:   dec.kind = K_ALU;
      2'b10:   dec.kind = K_ALUI;
      2'b11:   dec.kind = K_CMP;
      default: begin
        unique case (word[29:27])
          3'd1:    dec.kind = K_STOP;
          3'd2:    dec.kind = K_JMP;
          3'd3:    dec.kind = K_JREG;
          3'd4:    dec.kind = K_BRC;
          3'd5:    dec.kind = K_LDI;
          3'd6:    dec.kind = K_LOAD;
          3'd7:    dec.kind = K_STORE;
          default: dec.kind = K_NOP;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/fes_regfile.sv
module fes_regfile #(
  parameter int W = 32,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs_q [N];
  logic [W-1:0] wval;

  // register 0 keeps zero: any write to it stores zero
  assign wval = (waddr == '0) ? '0 : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wval;
    end
  end

  assign rd_a = regs_q[ra_a];
  assign rd_b = regs_q[ra_b];
endmodule

// File: rtl/fes_cyclimit.sv
module fes_cyclimit #(
  parameter int LOG = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic hit
);
  localparam logic [LOG:0] MAXC = {1'b1, {LOG{1'b0}}};
  logic [LOG:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (cnt_q != MAXC) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign hit = (cnt_q == MAXC);
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fes_pkg::*;
#(
  parameter int LOG_MAX_CYCLES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_req_valid,
  input  logic            imem_req_ready,
  output logic [XLEN-1:0] imem_req_addr,
  input  logic            imem_rsp_valid,
  input  logic [XLEN-1:0] imem_rsp_data,
  output logic            dmem_req_valid,
  input  logic            dmem_req_ready,
  output logic            dmem_req_we,
  output logic [XLEN-1:0] dmem_req_addr,
  output logic [XLEN-1:0] dmem_req_wdata,
  input  logic            dmem_rsp_valid,
  input  logic [XLEN-1:0] dmem_rsp_data,
  output logic [2:0]      alu_func,
  output logic [XLEN-1:0] alu_a,
  output logic [XLEN-1:0] alu_b,
  input  logic [XLEN-1:0] alu_result,
  input  logic            alu_flag,
  output logic            halted
);
  state_e          st_q, st_n;
  logic [XLEN-1:0] pc_q, pc_n, pc_inc;
  logic [XLEN-1:0] ir_q, ir_n;
  logic            flag_q, flag_n;
  logic [XLEN-1:0] daddr_q, daddr_n, dwdata_q, dwdata_n;
  logic            dwe_q, dwe_n;
  logic            lim_hit;
  logic [XLEN-1:0] dec_word;
  dec_t            dec;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr, rb_idx;
  logic [XLEN-1:0] rf_wdata, rd_a, rd_b;

  // the word being executed comes straight from the port; a data reply uses the held one
  assign dec_word = (st_q == ST_IWAIT) ? imem_rsp_data : ir_q;
  assign rb_idx   = (dec.kind == K_STORE) ? dec.rd : dec.rs2;
  assign pc_inc   = pc_q + 1'b1;

  fes_decode u_dec (.word(dec_word), .dec(dec));

  fes_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_a(dec.rs1), .rd_a(rd_a), .ra_b(rb_idx), .rd_b(rd_b)
  );

  fes_cyclimit #(.LOG(LOG_MAX_CYCLES)) u_lim (.clk(clk), .rst_n(rst_n), .hit(lim_hit));

  always_comb begin
    st_n     = st_q;
    pc_n     = pc_q;
    ir_n     = ir_q;
    flag_n   = flag_q;
    daddr_n  = daddr_q;
    dwe_n    = dwe_q;
    dwdata_n = dwdata_q;
    rf_we    = 1'b0;
    rf_waddr = dec.rd;
    rf_wdata = alu_result;
    unique case (st_q)
      ST_FETCH: if (imem_req_ready) st_n = ST_IWAIT;
      ST_IWAIT: begin
        if (imem_rsp_valid) begin
          ir_n = imem_rsp_data;
          st_n = ST_FETCH;
          pc_n = pc_inc;
          unique case (dec.kind)
            K_STOP: begin st_n = ST_HALT; pc_n = pc_q; end
            K_JMP:  pc_n = dec.imm;
            K_JREG: pc_n = rd_a;
            K_BRC:  if (flag_q) pc_n = dec.imm;
            K_LDI:  begin rf_we = 1'b1; rf_wdata = dec.imm; end
            K_ALU, K_ALUI: rf_we = 1'b1;
            K_CMP:  flag_n = alu_flag;
            K_LOAD, K_STORE: begin
              pc_n     = pc_q;
              st_n     = ST_DREQ;
              daddr_n  = rd_a + dec.imm;
              dwe_n    = (dec.kind == K_STORE);
              dwdata_n = rd_b;
            end
            default: ;
          endcase
        end
      end
      ST_DREQ: if (dmem_req_ready) st_n = ST_DWAIT;
      ST_DWAIT: begin
        if (dmem_rsp_valid) begin
          st_n     = ST_FETCH;
          pc_n     = pc_inc;
          rf_we    = !dwe_q;
          rf_wdata = dmem_rsp_data;
        end
      end
      default: ;
    endcase
    if (lim_hit) begin
      st_n  = ST_HALT;
      rf_we = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      flag_q   <= 1'b0;
      daddr_q  <= '0;
      dwe_q    <= 1'b0;
      dwdata_q <= '0;
    end else begin
      st_q     <= st_n;
      pc_q     <= pc_n;
      ir_q     <= ir_n;
      flag_q   <= flag_n;
      daddr_q  <= daddr_n;
      dwe_q    <= dwe_n;
      dwdata_q <= dwdata_n;
    end
  end

  assign imem_req_valid = (st_q == ST_FETCH) && !lim_hit;
  assign imem_req_addr  = pc_q;
  assign dmem_req_valid = (st_q == ST_DREQ) && !lim_hit;
  assign dmem_req_we    = dwe_q;
  assign dmem_req_addr  = daddr_q;
  assign dmem_req_wdata = dwdata_q;
  assign alu_func       = dec.func;
  assign alu_a          = rd_a;
  assign alu_b          = (dec.kind == K_ALUI) ? dec.imm : rd_b;
  assign halted         = (st_q == ST_HALT) || lim_hit;
endmodule

// File: rtl/fes_core_chk.sv
module fes_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        imem_req_valid,
  input logic        imem_req_ready,
  input logic [31:0] imem_req_addr,
  input logic        dmem_req_valid,
  input logic        dmem_req_ready,
  input logic        dmem_req_we,
  input logic [31:0] dmem_req_addr,
  input logic [31:0] dmem_req_wdata,
  input logic        halted
);
  assert_single_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_req_valid && dmem_req_valid));

  assert_ireq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid && !imem_req_ready |=> halted || (imem_req_valid && $stable(imem_req_addr)));

  assert_dreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req_valid && !dmem_req_ready |=> halted ||
      (dmem_req_valid && $stable(dmem_req_addr) && $stable(dmem_req_wdata) && $stable(dmem_req_we)));

  assert_no_fetch_while_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req_valid |=> !imem_req_valid);

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !imem_req_valid && !dmem_req_valid);
endmodule

bind fetch_exec_seq fes_core_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready), .imem_req_addr(imem_req_addr),
  .dmem_req_valid(dmem_req_valid), .dmem_req_ready(dmem_req_ready), .dmem_req_we(dmem_req_we),
  .dmem_req_addr(dmem_req_addr), .dmem_req_wdata(dmem_req_wdata), .halted(halted)
);

// File: tb/fetch_exec_seq_tb.sv
`timescale 1ns/1ps
module fetch_exec_seq_tb;
  localparam int LOGC = 9;
  localparam int MAXC = 1 << LOGC;

  function automatic logic [31:0] enc(int op, int rd, int rs1, int rs2, int imm);
    return (32'(op) << 27) | (32'(rd) << 23) | (32'(rs1) << 19) | (32'(rs2) << 15) | (32'(imm) & 32'hFFFF);
  endfunction

  // R3 encoding: 2 jump, 4 branch, 5 ldi, 6 load, 7 store, 8+f alu, 16+f alu-imm, 24+f compare
  localparam int PN = 26;
  localparam logic [31:0] PROG [PN] = '{
    enc(5,1,0,0,5),        enc(5,2,0,0,16'hFFFD),  enc(8,3,1,2,0),       enc(7,3,0,0,16'h10),
    enc(20,4,1,0,16'hFFFF), enc(7,4,0,0,16'h11),   enc(5,0,0,0,7),       enc(7,0,1,0,0),
    enc(6,5,1,0,16'hFFFE), enc(7,5,0,0,16'h12),    enc(24,0,1,2,0),      enc(4,0,0,0,20),
    enc(7,1,0,0,16'h13),   enc(26,0,2,1,0),        enc(4,0,0,0,17),      enc(7,2,0,0,16'h14),
    enc(1,0,0,0,0),        enc(2,0,0,0,20),        enc(1,0,0,0,0),       enc(1,0,0,0,0),
    enc(5,6,0,0,23),       enc(3,0,6,0,0),         enc(1,0,0,0,0),       enc(15,7,2,1,0),
    enc(7,7,0,0,16'h15),   enc(1,0,0,0,0)
  };

  typedef struct packed { logic we; logic [31:0] a; logic [31:0] d; } xv_t;
  localparam int XN = 7;
  localparam xv_t EXP [XN] = '{
    '{1'b1, 32'h10, 32'h2},        '{1'b1, 32'h11, 32'hFFFF_FFFA},
    '{1'b1, 32'h05, 32'h0},        '{1'b0, 32'h03, 32'h0},
    '{1'b1, 32'h12, 32'h103},      '{1'b1, 32'h13, 32'h5},
    '{1'b1, 32'h15, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic imem_req_valid, imem_req_ready, imem_rsp_valid;
  logic [31:0] imem_req_addr, imem_rsp_data;
  logic dmem_req_valid, dmem_req_ready, dmem_req_we, dmem_rsp_valid;
  logic [31:0] dmem_req_addr, dmem_req_wdata, dmem_rsp_data;
  logic [2:0] alu_func;
  logic [31:0] alu_a, alu_b, alu_result;
  logic alu_flag, halted;

  int n_chk = 0, n_bad = 0, tick = 0;
  int fetch_cnt = 0, acc_cnt = 0, req_after_halt = 0;
  bit pend_i = 0, pend_d = 0, stray_en = 1, prog_sel = 0, done = 0;
  logic [31:0] pend_ia, pend_dd, last_fetch;
  logic [31:0] dmem [64];
  xv_t acc_log [16];

  always #2.5 clk = ~clk;

  fetch_exec_seq #(.LOG_MAX_CYCLES(LOGC)) u_dut (.*);

  function automatic logic [32:0] alu_model(logic [2:0] f, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    logic fl;
    unique case (f)
      3'd0: begin r = a + b;  fl = (a == b); end
      3'd1: begin r = a - b;  fl = (a != b); end
      3'd2: begin r = a & b;  fl = ($signed(a) < $signed(b)); end
      3'd3: begin r = a | b;  fl = ($signed(a) >= $signed(b)); end
      3'd4: begin r = a ^ b;  fl = (a < b); end
      3'd5: begin r = a << b[4:0]; fl = (a >= b); end
      3'd6: begin r = a >> b[4:0]; fl = 1'b0; end
      default: begin r = 32'($signed(a) >>> b[4:0]); fl = 1'b0; end
    endcase
    return {fl, r};
  endfunction

  assign {alu_flag, alu_result} = alu_model(alu_func, alu_a, alu_b);

  function automatic logic [31:0] fetch_word(logic [31:0] a);
    if (prog_sel) return enc(2,0,0,0,0);
    if (a < PN) return PROG[a];
    return enc(1,0,0,0,0);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory responder: one cycle of latency after acceptance, fixed ready stalls
  initial begin
    imem_req_ready = 0; imem_rsp_valid = 0; imem_rsp_data = 0;
    dmem_req_ready = 0; dmem_rsp_valid = 0; dmem_rsp_data = 0;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h100 + 32'(i);
    forever begin
      @(negedge clk);
      tick++;
      imem_rsp_valid = 0;
      dmem_rsp_valid = 0;
      if (!rst_n) begin
        pend_i = 0; pend_d = 0;
      end else begin
        if (halted && (imem_req_valid || dmem_req_valid)) req_after_halt++;
        if (pend_i) begin imem_rsp_valid = 1; imem_rsp_data = fetch_word(pend_ia); pend_i = 0; end
        if (pend_d) begin dmem_rsp_valid = 1; dmem_rsp_data = pend_dd; pend_d = 0; end
        else if (stray_en && (tick % 5 == 2)) begin dmem_rsp_valid = 1; dmem_rsp_data = 32'hDEAD_BEEF; end
        imem_req_ready = (tick % 3 != 0);
        dmem_req_ready = (tick % 4 != 1);
        if (imem_req_valid && imem_req_ready) begin
          pend_i = 1; pend_ia = imem_req_addr; last_fetch = imem_req_addr; fetch_cnt++;
        end
        if (dmem_req_valid && dmem_req_ready) begin
          pend_d = 1;
          if (acc_cnt < 16) acc_log[acc_cnt] = '{dmem_req_we, dmem_req_addr, dmem_req_we ? dmem_req_wdata : 32'h0};
          acc_cnt++;
          if (dmem_req_we) dmem[dmem_req_addr[5:0]] = dmem_req_wdata;
          else pend_dd = dmem[dmem_req_addr[5:0]];
        end
      end
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(imem_req_valid == 1'b1, "R1", "imem_req_valid in reset", 32'(imem_req_valid), 32'd1);
    chk(imem_req_addr == 32'h0, "R1", "imem_req_addr in reset", imem_req_addr, 32'h0);
    chk(dmem_req_valid == 1'b0, "R1", "dmem_req_valid in reset", 32'(dmem_req_valid), 32'd0);
    chk(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    chk(halted == 1'b1, "R11", "halted after stop", 32'(halted), 32'd1);
    chk(last_fetch == 32'd25, "R6", "address of final fetch", last_fetch, 32'd25);
    // 15 straight-line words, then 17, 20, 21, 23, 24, 25
    chk(fetch_cnt == 21, "R2", "fetch count", 32'(fetch_cnt), 32'd21);
    chk(acc_cnt == XN, "R7", "data access count (skipped store)", 32'(acc_cnt), 32'(XN));
    repeat (6) @(negedge clk);
    chk(req_after_halt == 0, "R11", "requests after halt", 32'(req_after_halt), 32'd0);

    // vector walk: captured data accesses; stray pulses ran throughout (R10)
    for (int k = 0; k < XN; k++) begin
      string tg;
      unique case (k)
        0: tg = "R4"; 1: tg = "R9"; 2: tg = "R5"; 3: tg = "R8";
        4: tg = "R10"; 5: tg = "R7"; default: tg = "R6";
      endcase
      chk(acc_log[k].we == EXP[k].we, tg, $sformatf("access %0d we", k), 32'(acc_log[k].we), 32'(EXP[k].we));
      chk(acc_log[k].a == EXP[k].a, tg, $sformatf("access %0d addr", k), acc_log[k].a, EXP[k].a);
      chk(acc_log[k].d == EXP[k].d, tg, $sformatf("access %0d data", k), acc_log[k].d, EXP[k].d);
    end

    // R12 cycle limit with a program that jumps to itself
    prog_sel = 1; stray_en = 0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (MAXC - 1) @(negedge clk);
    chk(halted == 1'b0, "R12", "halted one edge before limit", 32'(halted), 32'd0);
    @(negedge clk);
    chk(halted == 1'b1, "R12", "halted at limit", 32'(halted), 32'd1);
    repeat (4) @(negedge clk);
    chk(halted == 1'b1 && !imem_req_valid, "R12", "halt held, no fetch", 32'(halted), 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule